// File: doc/BRIEF.md
# Remappable Address Decoder with Boot Override

This block turns a 32-bit bus address into a one-hot device select, a device-relative offset and an abort flag for four targets: an SDRAM chip select, a static memory chip select (CS1), a 16 KB internal SRAM and an 8 KB boot ROM. Decoding is purely combinational from the address. A small control register adds state that changes the decode. A 2-bit remap field chooses which device also answers at the bottom of the address space. An enable bit controls boot substitution.

A 4-bit boot strap vector is sampled while reset is held. When the strap asks for it, every access that would reach CS1 goes to the boot ROM instead, so the processor runs code from the ROM after reset. Software later clears the enable bit to restore CS1. The SRAM window is larger than the SRAM, so accesses above 16 KB wrap back onto it without a fault. Only the part of the ROM window beyond 8 KB raises an abort.

Top module: `addr_remap_dec`

## Requirements
- R1: While `rst` is high on a rising clock edge, remap is set to 00 and the substitution enable is set to 1; the decode of 0x00000000 just after reset reflects these values.
- R2: Addresses 0x20000000–0x2FFFFFFF select SDRAM (`sel_o` bit 0) with offset equal to the address minus 0x20000000 and no abort.
- R3: Addresses 0x60000000–0x60003FFF select SRAM (`sel_o` bit 2) with offset equal to address bits [13:0].
- R4: Addresses 0x60004000–0x7FFFFFFF also select SRAM with offset address bits [13:0] and never raise `abort_o`.
- R5: Addresses 0x80000000–0x80001FFF select ROM (`sel_o` bit 3) with offset address bits [12:0].
- R6: Addresses 0x80002000–0x9FFFFFFF raise `abort_o`, assert no select and give offset 0.
- R7: In the low window 0x00000000–0x0FFFFFFF, remap 01 selects SDRAM with offset bits [27:0], and remap 10 selects SRAM with offset bits [13:0].
- R8: In the low window with remap 00 or 11, the access follows the CS1 path with offset bits [27:0], and boot substitution applies there too.
- R9: Addresses 0x40000000–0x4FFFFFFF (default CS1 base and size) select CS1 (`sel_o` bit 1) with offset equal to the address minus the base.
- R10: When bit 2 of the captured strap is 1 and the enable is 1, every CS1-path access selects ROM instead, with offset address bits [12:0] and no abort.
- R11: A write (`ctrl_we_i` high at a rising edge) loads remap from `ctrl_wdata_i[1:0]` and the enable from `ctrl_wdata_i[2]`. The new values take effect after that edge. Writing 0 to the enable restores CS1 decoding, and writing 1 brings substitution back.
- R12: When bit 2 of the captured strap is 0, CS1-path accesses select CS1 whatever the enable holds.
- R13: All other addresses (0x10000000–0x1FFFFFFF, 0x30000000–0x3FFFFFFF, 0x50000000–0x5FFFFFFF, 0xA0000000 and above) assert no select, no abort and offset 0. At most one select is ever high.
- R14: The strap is frozen once reset is released, so later changes on `boot_cfg_i` do not change decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| boot_cfg_i | input | 4 | Boot strap vector; bit 2 requests boot ROM substitution |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 3 | Write data: [1:0] remap, [2] substitution enable |
| addr_i | input | 32 | Bus address to decode |
| sel_o | output | 4 | One-hot select: bit 0 SDRAM, bit 1 CS1, bit 2 SRAM, bit 3 ROM |
| abort_o | output | 1 | Access to the ROM hole beyond 8 KB |
| offset_o | output | 32 | Device-relative offset |

## Verification
The hardest case to reach is the interaction between the reset-captured strap and the software enable at the low alias window. A strap value can only be set by going through reset, and the enable only matters when that strap bit is 1. The stimulus therefore runs two full reset cycles: one with the substitution bit clear and the other strap bits set, and one with only that bit set. Right after each reset the strap pins are inverted. Under each captured strap, the bench writes every remap code twice, first with the enable set and then cleared. For each of these settings it sweeps all sixteen top address nibbles against boundary low offsets.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int AW       = 32;
    localparam int BOOT_W   = 4;
    localparam int BOOT_BIT = 2;
    localparam int CTRL_W   = 3;
    localparam int N_DEV    = 4;

    // window indices into the hit vector
    localparam int W_ZERO  = 0;
    localparam int W_SDRAM = 1;
    localparam int W_CS1   = 2;
    localparam int W_SRAM  = 3;
    localparam int W_HIGH  = 4;
    localparam int W_ROM   = 5;
    localparam int N_WIN   = 6;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        MAP_CS1_LO = 2'b00,
        MAP_SDRAM  = 2'b01,
        MAP_SRAM   = 2'b10,
        MAP_CS1_HI = 2'b11
    } remap_e;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_SDRAM = 3'd1,
        RG_CS1   = 3'd2,
        RG_SRAM  = 3'd3,
        RG_ROM   = 3'd4,
        RG_FAULT = 3'd5
    } region_e;

    // bit 0 sdram ... bit 3 rom
    typedef struct packed {
        logic rom;
        logic sram;
        logic cs1;
        logic sdram;
    } dev_sel_t;

    // write data bit 2 enable, bits 1:0 remap
    typedef struct packed {
        logic   sub_allow;
        remap_e remap;
    } ctrl_t;

    typedef struct packed {
        region_e region;
        addr_t   offset;
    } decode_t;

    function automatic addr_t low_bits(addr_t a, int unsigned sh);
        return a & ((addr_t'(1) << sh) - addr_t'(1));
    endfunction

    function automatic dev_sel_t region_to_sel(region_e r);
        dev_sel_t s;
        s       = '0;
        s.sdram = (r == RG_SDRAM);
        s.cs1   = (r == RG_CS1);
        s.sram  = (r == RG_SRAM);
        s.rom   = (r == RG_ROM);
        return s;
    endfunction

endpackage

// File: rtl/addr_ctrl_regs.sv
module addr_ctrl_regs
    import addr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_i,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              sub_active_o
);

    ctrl_t ctrl_q;
    logic  strap_q;

    // strap follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.remap     <= MAP_CS1_LO;
            ctrl_q.sub_allow <= 1'b1;
        end else if (we_i) begin
            ctrl_q <= ctrl_t'(wdata_i);
        end
    end

    assign ctrl_o       = ctrl_q;
    assign sub_active_o = strap_q & ctrl_q.sub_allow;

    p_ctrl_write_r11: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (ctrl_q == ctrl_t'($past(wdata_i))));

    p_strap_hold_r14: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));

    p_ctrl_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(ctrl_q));

endmodule

// File: rtl/addr_window_match.sv
module addr_window_match
    import addr_map_pkg::*;
#(
    parameter int               N      = N_WIN,
    parameter logic [N*AW-1:0]  BASES  = '0,
    parameter logic [N*8-1:0]   SHIFTS = '0
) (
    input  addr_t        addr_i,
    output logic [N-1:0] hit_o
);

    for (genvar i = 0; i < N; i++) begin : g_win
        localparam int unsigned SH   = int'(SHIFTS[i*8 +: 8]);
        localparam addr_t       BASE = BASES[i*AW +: AW];
        localparam addr_t       TAG  = BASE >> SH;
        assign hit_o[i] = ((addr_i >> SH) == TAG);
    end

endmodule

// File: rtl/addr_route.sv
module addr_route
    import addr_map_pkg::*;
#(
    parameter int unsigned ZERO_SHIFT  = 28,
    parameter int unsigned SDRAM_SHIFT = 28,
    parameter int unsigned CS1_SHIFT   = 28,
    parameter int unsigned SRAM_SHIFT  = 14,
    parameter int unsigned ROM_SHIFT   = 13
) (
    input  addr_t            addr_i,
    input  logic [N_WIN-1:0] hit_i,
    input  ctrl_t            ctrl_i,
    input  logic             sub_active_i,
    output decode_t          dec_o
);

    decode_t cs1_path;

    // CS1 target, possibly taken over by the boot ROM
    always_comb begin
        if (sub_active_i) begin
            cs1_path.region = RG_ROM;
            cs1_path.offset = low_bits(addr_i, ROM_SHIFT);
        end else begin
            cs1_path.region = RG_CS1;
            cs1_path.offset = low_bits(addr_i, CS1_SHIFT);
        end
    end

    always_comb begin
        dec_o.region = RG_NONE;
        dec_o.offset = '0;
        if (hit_i[W_ZERO]) begin
            unique case (ctrl_i.remap)
                MAP_SDRAM: begin
                    dec_o.region = RG_SDRAM;
                    dec_o.offset = low_bits(addr_i, ZERO_SHIFT);
                end
                MAP_SRAM: begin
                    dec_o.region = RG_SRAM;
                    dec_o.offset = low_bits(addr_i, SRAM_SHIFT);
                end
                default: begin
                    dec_o = cs1_path;
                end
            endcase
        end else if (hit_i[W_SDRAM]) begin
            dec_o.region = RG_SDRAM;
            dec_o.offset = low_bits(addr_i, SDRAM_SHIFT);
        end else if (hit_i[W_CS1]) begin
            dec_o = cs1_path;
        end else if (hit_i[W_SRAM]) begin
            dec_o.region = RG_SRAM;
            dec_o.offset = low_bits(addr_i, SRAM_SHIFT);
        end else if (hit_i[W_HIGH]) begin
            if (hit_i[W_ROM]) begin
                dec_o.region = RG_ROM;
                dec_o.offset = low_bits(addr_i, ROM_SHIFT);
            end else begin
                dec_o.region = RG_FAULT;
            end
        end
    end

endmodule

// File: rtl/addr_remap_dec.sv
module addr_remap_dec
    import addr_map_pkg::*;
#(
    parameter logic [AW-1:0] ZERO_BASE      = 32'h0000_0000,
    parameter int unsigned   ZERO_SHIFT     = 28,
    parameter logic [AW-1:0] SDRAM_BASE     = 32'h2000_0000,
    parameter int unsigned   SDRAM_SHIFT    = 28,
    parameter logic [AW-1:0] CS1_BASE       = 32'h4000_0000,
    parameter int unsigned   CS1_SHIFT      = 28,
    parameter logic [AW-1:0] SRAM_BASE      = 32'h6000_0000,
    parameter int unsigned   SRAM_WIN_SHIFT = 29,
    parameter int unsigned   SRAM_SHIFT     = 14,
    parameter logic [AW-1:0] ROM_BASE       = 32'h8000_0000,
    parameter int unsigned   ROM_WIN_SHIFT  = 29,
    parameter int unsigned   ROM_SHIFT      = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BOOT_W-1:0] boot_cfg_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic [AW-1:0]     addr_i,
    output logic [N_DEV-1:0]  sel_o,
    output logic              abort_o,
    output logic [AW-1:0]     offset_o
);

    localparam logic [N_WIN*AW-1:0] WIN_BASES =
        {ROM_BASE, ROM_BASE, SRAM_BASE, CS1_BASE, SDRAM_BASE, ZERO_BASE};
    localparam logic [N_WIN*8-1:0] WIN_SHIFTS =
        {8'(ROM_SHIFT), 8'(ROM_WIN_SHIFT), 8'(SRAM_WIN_SHIFT),
         8'(CS1_SHIFT), 8'(SDRAM_SHIFT), 8'(ZERO_SHIFT)};

    ctrl_t            ctrl;
    logic             sub_active;
    logic [N_WIN-1:0] hit;
    decode_t          dec;
    dev_sel_t         sel;
    logic             unused_boot_bits;

    assign unused_boot_bits = ^boot_cfg_i;

    addr_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .strap_i     (boot_cfg_i[BOOT_BIT]),
        .we_i        (ctrl_we_i),
        .wdata_i     (ctrl_wdata_i),
        .ctrl_o      (ctrl),
        .sub_active_o(sub_active)
    );

    addr_window_match #(
        .N     (N_WIN),
        .BASES (WIN_BASES),
        .SHIFTS(WIN_SHIFTS)
    ) u_match (
        .addr_i(addr_i),
        .hit_o (hit)
    );

    addr_route #(
        .ZERO_SHIFT (ZERO_SHIFT),
        .SDRAM_SHIFT(SDRAM_SHIFT),
        .CS1_SHIFT  (CS1_SHIFT),
        .SRAM_SHIFT (SRAM_SHIFT),
        .ROM_SHIFT  (ROM_SHIFT)
    ) u_route (
        .addr_i      (addr_i),
        .hit_i       (hit),
        .ctrl_i      (ctrl),
        .sub_active_i(sub_active),
        .dec_o       (dec)
    );

    assign sel      = region_to_sel(dec.region);
    assign sel_o    = sel;
    assign abort_o  = (dec.region == RG_FAULT);
    assign offset_o = dec.offset;

    p_sel_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    p_abort_nosel_r6: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (sel_o == '0 && offset_o == '0));

    p_rom_hole_r6: assert property (@(posedge clk) disable iff (rst)
        ((addr_i >> ROM_WIN_SHIFT) == (ROM_BASE >> ROM_WIN_SHIFT) &&
         (addr_i >> ROM_SHIFT) != (ROM_BASE >> ROM_SHIFT)) |-> abort_o);

    p_sram_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        ((addr_i >> SRAM_WIN_SHIFT) == (SRAM_BASE >> SRAM_WIN_SHIFT)) |->
        (sel_o == 4'b0100 && !abort_o &&
         offset_o == (addr_i & ((32'h1 << SRAM_SHIFT) - 32'h1))));

    p_sub_blocks_cs1_r10: assert property (@(posedge clk) disable iff (rst)
        sub_active |-> !sel_o[1]);

endmodule

// File: tb/addr_remap_dec_tb.sv
module addr_remap_dec_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  boot_cfg = 4'b0000;
    logic        we = 1'b0;
    logic [2:0]  wdata = 3'b000;
    logic [31:0] addr = 32'h0;
    logic [3:0]  sel;
    logic        abort;
    logic [31:0] offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addr_remap_dec u_dut (
        .clk         (clk),
        .rst         (rst),
        .boot_cfg_i  (boot_cfg),
        .ctrl_we_i   (we),
        .ctrl_wdata_i(wdata),
        .addr_i      (addr),
        .sel_o       (sel),
        .abort_o     (abort),
        .offset_o    (offset)
    );

    // expected decode from the requirements
    task automatic model(input logic [31:0] a, input logic [1:0] rm, input bit en,
                         input bit strap, output logic [3:0] s, output bit ab,
                         output logic [31:0] off, output string tag);
        logic [3:0] nib;
        bit         cs1p;
        nib  = a[31:28];
        s    = 4'b0000;
        ab   = 1'b0;
        off  = 32'h0;
        cs1p = 1'b0;
        tag  = "R13";
        if (nib == 4'h0) begin
            if (rm == 2'b01) begin
                s = 4'b0001; off = {4'h0, a[27:0]}; tag = "R7";
            end else if (rm == 2'b10) begin
                s = 4'b0100; off = {18'h0, a[13:0]}; tag = "R7";
            end else begin
                cs1p = 1'b1; tag = "R8";
            end
        end else if (nib == 4'h2) begin
            s = 4'b0001; off = {4'h0, a[27:0]}; tag = "R2";
        end else if (nib == 4'h4) begin
            cs1p = 1'b1; tag = "R9";
        end else if (nib == 4'h6 || nib == 4'h7) begin
            s = 4'b0100; off = {18'h0, a[13:0]};
            tag = (a < 32'h6000_4000) ? "R3" : "R4";
        end else if (nib == 4'h8 || nib == 4'h9) begin
            if (a <= 32'h8000_1FFF) begin
                s = 4'b1000; off = {19'h0, a[12:0]}; tag = "R5";
            end else begin
                ab = 1'b1; tag = "R6";
            end
        end
        if (cs1p) begin
            if (strap && en) begin
                s = 4'b1000; off = {19'h0, a[12:0]}; tag = {tag, " R10"};
            end else begin
                s = 4'b0010; off = {4'h0, a[27:0]};
                tag = strap ? {tag, " R11"} : {tag, " R12"};
            end
        end
    endtask

    task automatic check_one(input logic [31:0] a, input logic [1:0] rm, input bit en,
                             input bit strap, input string force_tag);
        logic [3:0]  es;
        bit          eab;
        logic [31:0] eoff;
        string       tag;
        @(negedge clk);
        addr = a;
        #2;
        model(a, rm, en, strap, es, eab, eoff, tag);
        if (force_tag.len() != 0) tag = force_tag;
        checks++;
        if (sel !== es || abort !== eab || offset !== eoff) begin
            fails++;
            $display("FAIL %s addr=%h sel=%b exp=%b abort=%b exp=%b offset=%h exp=%h",
                     tag, a, sel, es, abort, eab, offset, eoff);
        end
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        @(negedge clk);
        rst      = 1'b1;
        boot_cfg = cfg;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst      = 1'b0;
        boot_cfg = ~cfg;   // R14: pin changes after reset are ignored
    endtask

    task automatic write_ctrl(input logic [1:0] rm, input bit en);
        @(negedge clk);
        we    = 1'b1;
        wdata = {en, rm};
        @(negedge clk);
        we    = 1'b0;
    endtask

    initial begin
        logic [27:0] lows [8];
        lows[0] = 28'h0000000; lows[1] = 28'h0001FFF; lows[2] = 28'h0002000;
        lows[3] = 28'h0003FFF; lows[4] = 28'h0004000; lows[5] = 28'hFFFFFFF;
        lows[6] = 28'h8000004; lows[7] = 28'h1234567;

        for (int b = 0; b < 2; b++) begin
            bit strap;
            strap = (b == 1);
            do_reset(strap ? 4'b0100 : 4'b1011);
            // R1 reset defaults seen through the low window, R14 strap frozen
            check_one(32'h0000_0000, 2'b00, 1'b1, strap, strap ? "R1 R14 R10" : "R1 R14 R12");
            check_one(32'h0000_2468, 2'b00, 1'b1, strap, strap ? "R1 R14 R10" : "R1 R14 R12");
            check_one(32'h4000_0010, 2'b00, 1'b1, strap, "R14");
            for (int r = 0; r < 4; r++) begin
                for (int e = 1; e >= 0; e--) begin
                    write_ctrl(2'(r), e[0]);
                    for (int n = 0; n < 16; n++) begin
                        for (int l = 0; l < 8; l++) begin
                            check_one({4'(n), lows[l]}, 2'(r), e[0], strap, "");
                        end
                    end
                end
            end
            // R11: re-enable after clearing
            write_ctrl(2'b00, 1'b0);
            check_one(32'h4000_0100, 2'b00, 1'b0, strap, strap ? "R11 off" : "R12 off");
            write_ctrl(2'b00, 1'b1);
            check_one(32'h4000_0100, 2'b00, 1'b1, strap, strap ? "R11 on" : "R12 on");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule